// File: doc/BRIEF.md
# Configurable UART with Fractional Stop Length

This block is a full-duplex asynchronous serial transceiver for a host that talks to it over a small register bus. The host sets the character format and writes bytes into a transmit FIFO. The transmitter serialises each byte onto the line as a start bit, the data bits least significant first, an optional parity bit and a stop interval. The receiver watches the line, qualifies start bits, rebuilds each character into a receive FIFO and raises sticky error flags.

All bit timing comes from an external 16x oversampling enable, `tick16_i`, which pulses for one clock. A bit time is 16 ticks. The stop interval is set in single ticks from one to two bit times. A pair of active-low flow-control lines throttles traffic in both directions: clear-to-send gates the start of each new transmit character, and request-to-send tells the far end to pause while the receive FIFO is filling up.

Bus map: address 0 is data (a write pushes a transmit byte, a read returns and pops the oldest received byte). Address 1 is control. Address 2 is the stop length. Address 3 is status and flag clear.

Top module: `uartx_top`

## Requirements
- R1: Control bits [1:0] select the character length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of a written byte above the length are not sent. A received character reads back zero-extended to 8 bits.
- R2: `txd_o` idles high. A transmitted frame is a low start bit, then the data bits least significant first, then the parity bit when enabled, then a high stop interval.
- R3: Control bits [3:2] select parity: 00 none, 01 even (data plus parity has an even count of ones), 10 odd (the count is odd); 11 is reserved.
- R4: Stop-length register bits [4:0] at address 2 hold a value N. The stop interval lasts 16+min(N,16) ticks. Back-to-back 8-bit characters without parity therefore start 160+min(N,16) ticks apart.
- R5: The receiver validates a start bit by sampling the line 8 ticks after it first sees it low. A low pulse that has ended by then produces no character. Each later bit is sampled 16 ticks after the previous sample.
- R6: A received character whose parity check fails sets status bit 0 and is still stored in the receive FIFO.
- R7: A received character whose first stop sample is low sets status bit 1 and is still stored.
- R8: A character that completes while the receive FIFO is full is dropped, sets status bit 2, and leaves the FIFO contents unchanged.
- R9: Status bits [2:0] stay set until the host writes a 1 to that bit position at address 3. Writing 0 leaves them unchanged.
- R10: When control bit 4 is 1, a new transmit character starts only while `cts_n_i` is low. When control bit 4 is 0, `cts_n_i` is ignored.
- R11: When control bit 4 is 1, `rts_n_o` is high while the receive FIFO holds at least RTS_LEVEL characters and low otherwise. When control bit 4 is 0, `rts_n_o` is low.
- R12: The transmit FIFO holds TX_DEPTH bytes, which go out in write order. A data write while it is full is dropped. Status bit 4 flags transmit FIFO full and status bit 3 flags receive FIFO empty. A data read while the receive FIFO is empty returns 0 and pops nothing.
- R13: After reset, `txd_o` is high, `rts_n_o` is low, the status byte reads 8'h08 and all control fields are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | 16x oversampling enable, one clock wide |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops receive data at address 0) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_n_o | output | 1 | Request to send, active low |
| cts_n_i | input | 1 | Clear to send, active low |

## Verification
The transmit path is looped back to the receiver with three formats: 8 bits without parity, 5 bits with even parity and 7 bits with odd parity. Each uses a byte whose upper bits must be dropped and whose ones count makes the parity bit differ between modes. Frame spacing is measured with stop values 0, 8, 16 and an out-of-range 31 using all-ones bytes, so only start bits produce falling edges and the spacing isolates the stop interval. Frames driven by the bench carry a wrong parity bit, a low stop bit or a glitch shorter than the qualification window, which separates each error flag from the others and from a false start. Flow control is tried by holding clear-to-send high over a full transmit FIFO and by filling the receive FIFO past its threshold and beyond its depth.

// File: rtl/uartx_pkg.sv
package uartx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_RSVD = 2'b11
   } par_mode_t;

   typedef struct packed {
      logic [1:0] len_sel;
      par_mode_t  par;
   } frame_cfg_t;

   function automatic logic [7:0] len_mask(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8'h1F;
         2'd1:    return 8'h3F;
         2'd2:    return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic has_parity(input par_mode_t p);
      return (p == PAR_EVEN) || (p == PAR_ODD);
   endfunction

endpackage

// File: rtl/uartx_fifo.sv
module uartx_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [W-1:0]  din_i,
   input  logic          pop_i,
   output logic [W-1:0]  dout_o,
   output logic          empty_o,
   output logic [CW-1:0] count_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uartx_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("uartx_fifo: W must be positive");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [CW-1:0] wp_q, rp_q;

   assign count_o = wp_q - rp_q;
   assign empty_o = (wp_q == rp_q);
   assign dout_o  = mem_q[rp_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push_i) begin
            mem_q[wp_q[AW-1:0]] <= din_i;
            wp_q <= wp_q + 1'b1;
         end
         if (pop_i) rp_q <= rp_q + 1'b1;
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (count_o != CW'(DEPTH)));

   // R12
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/uartx_tx.sv
module uartx_tx
   import uartx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       go_i,
   input  logic [7:0] data_i,
   input  frame_cfg_t cfg_i,
   input  logic [4:0] stop_i,
   output logic       pop_o,
   output logic       txd_o
);

   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

   tx_st_t     st_q;
   logic [4:0] cnt_q;
   logic [2:0] idx_q;
   logic [7:0] sh_q;
   logic       pbit_q;
   frame_cfg_t cfg_q;
   logic [4:0] stop_last_q;

   logic [7:0] ld_data;
   logic       ld_pbit;
   logic [4:0] ld_stop_last;
   logic       stop_done;
   logic [2:0] last_idx;

   assign ld_data      = data_i & len_mask(cfg_i.len_sel);
   assign ld_pbit      = (^ld_data) ^ (cfg_i.par == PAR_ODD);
   assign ld_stop_last = 5'd15 + ((stop_i > 5'd16) ? 5'd16 : stop_i);
   assign stop_done    = (st_q == T_STOP) && (cnt_q == stop_last_q);
   assign last_idx     = {1'b0, cfg_q.len_sel} + 3'd4;
   assign pop_o        = tick_i && go_i && ((st_q == T_IDLE) || stop_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= T_IDLE;
         cnt_q       <= '0;
         idx_q       <= '0;
         sh_q        <= '0;
         pbit_q      <= 1'b0;
         cfg_q       <= '0;
         stop_last_q <= 5'd15;
      end else if (tick_i) begin
         if (pop_o) begin
            st_q        <= T_START;
            cnt_q       <= '0;
            sh_q        <= ld_data;
            pbit_q      <= ld_pbit;
            cfg_q       <= cfg_i;
            stop_last_q <= ld_stop_last;
         end else begin
            case (st_q)
               T_START: begin
                  if (cnt_q == 5'd15) begin
                     st_q  <= T_DATA;
                     cnt_q <= '0;
                     idx_q <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               T_DATA: begin
                  if (cnt_q == 5'd15) begin
                     cnt_q <= '0;
                     sh_q  <= {1'b0, sh_q[7:1]};
                     if (idx_q == last_idx)
                        st_q <= has_parity(cfg_q.par) ? T_PAR : T_STOP;
                     else
                        idx_q <= idx_q + 1'b1;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               T_PAR: begin
                  if (cnt_q == 5'd15) begin
                     st_q  <= T_STOP;
                     cnt_q <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               T_STOP: begin
                  if (stop_done) st_q <= T_IDLE;
                  else           cnt_q <= cnt_q + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (st_q)
         T_START: txd_o = 1'b0;
         T_DATA:  txd_o = sh_q[0];
         T_PAR:   txd_o = pbit_q;
         default: txd_o = 1'b1;
      endcase
   end

   // R4
   stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == T_STOP) |-> (cnt_q <= stop_last_q && stop_last_q <= 5'd31 && stop_last_q >= 5'd15));

endmodule

// File: rtl/uartx_rx.sv
module uartx_rx
   import uartx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  frame_cfg_t cfg_i,
   output logic       push_o,
   output logic [7:0] data_o,
   output logic       perr_o,
   output logic       ferr_o
);

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("uartx_rx: SYNC_STAGES must be between 1 and 4");
   end

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;

   logic rxs;

   if (SYNC_STAGES == 1) begin : g_sync_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b1;
         else        s_q <= rxd_i;
      end
      assign rxs = s_q;
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= '1;
         else        s_q <= {s_q[SYNC_STAGES-2:0], rxd_i};
      end
      assign rxs = s_q[SYNC_STAGES-1];
   end

   rx_st_t     st_q;
   logic [3:0] cnt_q;
   logic [2:0] idx_q;
   logic [7:0] acc_q;
   logic       par_q;
   logic       perr_q;
   frame_cfg_t cfg_q;
   logic [2:0] last_idx;

   assign last_idx = {1'b0, cfg_q.len_sel} + 3'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= R_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         acc_q  <= '0;
         par_q  <= 1'b0;
         perr_q <= 1'b0;
         cfg_q  <= '0;
         push_o <= 1'b0;
         data_o <= '0;
         perr_o <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         push_o <= 1'b0;
         if (tick_i) begin
            case (st_q)
               R_IDLE: begin
                  if (!rxs) begin
                     st_q  <= R_START;
                     cnt_q <= '0;
                     cfg_q <= cfg_i;
                  end
               end
               R_START: begin
                  if (cnt_q == 4'd7) begin
                     cnt_q  <= '0;
                     idx_q  <= '0;
                     acc_q  <= '0;
                     par_q  <= 1'b0;
                     perr_q <= 1'b0;
                     st_q   <= rxs ? R_IDLE : R_DATA;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               R_DATA: begin
                  if (cnt_q == 4'd15) begin
                     cnt_q        <= '0;
                     acc_q[idx_q] <= rxs;
                     par_q        <= par_q ^ rxs;
                     if (idx_q == last_idx)
                        st_q <= has_parity(cfg_q.par) ? R_PAR : R_STOP;
                     else
                        idx_q <= idx_q + 1'b1;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               R_PAR: begin
                  if (cnt_q == 4'd15) begin
                     cnt_q  <= '0;
                     perr_q <= par_q ^ rxs ^ (cfg_q.par == PAR_ODD);
                     st_q   <= R_STOP;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               R_STOP: begin
                  if (cnt_q == 4'd15) begin
                     push_o <= 1'b1;
                     data_o <= acc_q;
                     perr_o <= perr_q;
                     ferr_o <= !rxs;
                     st_q   <= R_IDLE;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: st_q <= R_IDLE;
            endcase
         end
      end
   end

   // R5
   start_seen_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != R_IDLE && $past(st_q) == R_IDLE) |-> !$past(rxs));

endmodule

// File: rtl/uartx_top.sv
module uartx_top
   import uartx_pkg::*;
#(
   parameter int unsigned TX_DEPTH    = 4,
   parameter int unsigned RX_DEPTH    = 4,
   parameter int unsigned RTS_LEVEL   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16_i,
   input  logic [1:0] bus_addr_i,
   input  logic       bus_wr_i,
   input  logic       bus_rd_i,
   input  logic [7:0] bus_wdata_i,
   output logic [7:0] bus_rdata_o,
   output logic       txd_o,
   input  logic       rxd_i,
   output logic       rts_n_o,
   input  logic       cts_n_i
);

   localparam int unsigned TXCW = $clog2(TX_DEPTH) + 1;
   localparam int unsigned RXCW = $clog2(RX_DEPTH) + 1;

   if (RTS_LEVEL < 1 || RTS_LEVEL > RX_DEPTH) begin : g_bad_level
      $error("uartx_top: RTS_LEVEL must lie in 1..RX_DEPTH");
   end

   logic [4:0] ctrl_q;
   logic [4:0] stop_q;
   logic [2:0] flags_q;
   logic [1:0] cts_q;
   logic       cts_s;
   logic       flow_en;
   frame_cfg_t cfg;

   logic            tx_empty, tx_full, tx_push, tx_pop, tx_go;
   logic [7:0]      tx_dout;
   logic [TXCW-1:0] tx_cnt;
   logic            rx_empty, rx_full, rx_fifo_push, rx_pop;
   logic [7:0]      rx_dout;
   logic [RXCW-1:0] rx_cnt;
   logic            rx_push, rx_perr, rx_ferr;
   logic [7:0]      rx_data;
   logic [2:0]      flag_set, flag_clr;
   logic            wr_data, wr_clr;

   assign flow_en     = ctrl_q[4];
   assign cfg.len_sel = ctrl_q[1:0];
   assign cfg.par     = par_mode_t'(ctrl_q[3:2]);
   assign cts_s       = cts_q[1];

   assign wr_data      = bus_wr_i && (bus_addr_i == 2'd0);
   assign wr_clr       = bus_wr_i && (bus_addr_i == 2'd3);
   assign tx_full      = (tx_cnt == TXCW'(TX_DEPTH));
   assign rx_full      = (rx_cnt == RXCW'(RX_DEPTH));
   assign tx_push      = wr_data && !tx_full;
   assign tx_go        = !tx_empty && (!flow_en || !cts_s);
   assign rx_fifo_push = rx_push && !rx_full;
   assign rx_pop       = bus_rd_i && (bus_addr_i == 2'd0) && !rx_empty;
   assign rts_n_o      = flow_en && (rx_cnt >= RXCW'(RTS_LEVEL));

   assign flag_set = {rx_push && rx_full, rx_push && rx_ferr, rx_push && rx_perr};
   assign flag_clr = wr_clr ? bus_wdata_i[2:0] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         stop_q  <= '0;
         flags_q <= '0;
         cts_q   <= 2'b11;
      end else begin
         cts_q   <= {cts_q[0], cts_n_i};
         flags_q <= (flags_q & ~flag_clr) | flag_set;
         if (bus_wr_i && bus_addr_i == 2'd1) ctrl_q <= bus_wdata_i[4:0];
         if (bus_wr_i && bus_addr_i == 2'd2) stop_q <= bus_wdata_i[4:0];
      end
   end

   always_comb begin
      case (bus_addr_i)
         2'd0:    bus_rdata_o = rx_empty ? 8'h00 : rx_dout;
         2'd1:    bus_rdata_o = {3'b000, ctrl_q};
         2'd2:    bus_rdata_o = {3'b000, stop_q};
         default: bus_rdata_o = {3'b000, tx_full, rx_empty, flags_q};
      endcase
   end

   uartx_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(tx_push), .din_i(bus_wdata_i),
      .pop_i(tx_pop), .dout_o(tx_dout),
      .empty_o(tx_empty), .count_o(tx_cnt)
   );

   uartx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(rx_fifo_push), .din_i(rx_data),
      .pop_i(rx_pop), .dout_o(rx_dout),
      .empty_o(rx_empty), .count_o(rx_cnt)
   );

   uartx_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick16_i),
      .go_i(tx_go), .data_i(tx_dout), .cfg_i(cfg), .stop_i(stop_q),
      .pop_o(tx_pop), .txd_o(txd_o)
   );

   uartx_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick16_i),
      .rxd_i(rxd_i), .cfg_i(cfg),
      .push_o(rx_push), .data_o(rx_data),
      .perr_o(rx_perr), .ferr_o(rx_ferr)
   );

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags_q) & ~flags_q)) |-> $past(bus_wr_i && bus_addr_i == 2'd3));

   // R10
   cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (!flow_en || !cts_s));

   // R11
   rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && rx_full) |-> rts_n_o);

endmodule

// File: tb/uartx_top_tb_top.sv
module uartx_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       txd;
   logic       rxd;
   logic       rts_n;
   logic       cts_n = 1'b0;
   logic       loop_en = 1'b0;
   logic       drv_rxd = 1'b1;

   int n_checks = 0;
   int n_err = 0;
   bit done = 0;

   logic [1:0] tdiv = '0;
   int         cyc = 0;
   logic       prev_txd = 1'b1;
   int         fall_cnt = 0;
   int         last_fall = 0;
   int         prev_fall = 0;

   always #5 clk = ~clk;

   assign rxd = loop_en ? txd : drv_rxd;

   always @(posedge clk) begin
      tdiv   <= tdiv + 1'b1;
      tick16 <= (tdiv == 2'd3);
   end

   always @(negedge clk) begin
      cyc      <= cyc + 1;
      prev_txd <= txd;
      if (prev_txd && !txd) begin
         fall_cnt  <= fall_cnt + 1;
         prev_fall <= last_fall;
         last_fall <= cyc;
      end
   end

   uartx_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick16_i(tick16),
      .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .txd_o(txd), .rxd_i(rxd), .rts_n_o(rts_n), .cts_n_i(cts_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic decode_tx(input int nbits, input bit par, output logic [7:0] val,
                            output logic pbit, output logic start_ok, output logic stop_ok);
      int guard = 0;
      while (txd === 1'b1 && guard < 6000) begin
         @(negedge clk);
         guard++;
      end
      wait_clk(32);
      start_ok = (txd == 1'b0);
      val = '0;
      for (int i = 0; i < nbits; i++) begin
         wait_clk(64);
         val[i] = txd;
      end
      pbit = 1'b0;
      if (par) begin
         wait_clk(64);
         pbit = txd;
      end
      wait_clk(64);
      stop_ok = (txd == 1'b1);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nbits, input int pmode,
                             input bit bad_par, input logic stop_val);
      logic ones = 1'b0;
      drv_rxd = 1'b0;
      wait_clk(64);
      for (int i = 0; i < nbits; i++) begin
         drv_rxd = d[i];
         ones ^= d[i];
         wait_clk(64);
      end
      if (pmode != 0) begin
         drv_rxd = ones ^ (pmode == 2) ^ bad_par;
         wait_clk(64);
      end
      drv_rxd = stop_val;
      wait_clk(64);
      drv_rxd = 1'b1;
      wait_clk(64);
   endtask

   task automatic t_reset();
      logic [7:0] r;
      check(txd == 1'b1, "R13 txd idle after reset", txd, 1);
      check(rts_n == 1'b0, "R13 rts_n after reset", rts_n, 0);
      bus_read(2'd3, r);
      check(r == 8'h08, "R13 status after reset", r, 8'h08);
      bus_read(2'd1, r);
      check(r == 8'h00, "R13 control after reset", r, 0);
      bus_read(2'd0, r);
      check(r == 8'h00, "R12 read of empty rx fifo", r, 0);
   endtask

   task automatic t_loop(input logic [7:0] ctrl, input logic [7:0] wr, input int nbits,
                         input bit par, input logic [7:0] exp_val, input logic exp_pbit,
                         input string tag);
      logic [7:0] v, r;
      logic pb, so, sp;
      bus_write(2'd1, ctrl);
      loop_en = 1'b1;
      bus_write(2'd0, wr);
      decode_tx(nbits, par, v, pb, so, sp);
      check(so == 1'b1, {tag, " R2 start bit low"}, so, 1);
      check(v == exp_val, {tag, " R1 R2 serial data bits"}, v, exp_val);
      if (par) check(pb == exp_pbit, {tag, " R3 parity bit"}, pb, exp_pbit);
      check(sp == 1'b1, {tag, " R2 stop bit high"}, sp, 1);
      wait_clk(80);
      bus_read(2'd0, r);
      check(r == exp_val, {tag, " R1 received value"}, r, exp_val);
      bus_read(2'd3, r);
      check(r == 8'h08, {tag, " R3 no error flags after loopback"}, r, 8'h08);
      loop_en = 1'b0;
   endtask

   task automatic t_stop(input logic [4:0] n);
      int base, guard, eff, exp_d;
      eff = (n > 16) ? 16 : int'(n);
      exp_d = (160 + eff) * 4;
      bus_write(2'd1, 8'h03);
      bus_write(2'd2, {3'b000, n});
      base = fall_cnt;
      bus_write(2'd0, 8'hFF);
      bus_write(2'd0, 8'hFF);
      guard = 0;
      while (fall_cnt < base + 2 && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      check((last_fall - prev_fall) == exp_d, "R4 frame spacing for stop length",
            last_fall - prev_fall, exp_d);
      wait_clk(900);
   endtask

   task automatic t_perr();
      logic [7:0] r;
      bus_write(2'd1, 8'h07);
      send_frame(8'h5A, 8, 1, 1'b1, 1'b1);
      bus_read(2'd3, r);
      check(r[0] == 1'b1, "R6 parity error flag", r[0], 1);
      check(r[1] == 1'b0, "R7 no framing flag on parity error", r[1], 0);
      bus_write(2'd3, 8'h00);
      bus_read(2'd3, r);
      check(r[0] == 1'b1, "R9 zero write keeps flag", r[0], 1);
      bus_read(2'd0, r);
      check(r == 8'h5A, "R6 char stored despite parity error", r, 8'h5A);
      bus_write(2'd3, 8'h01);
      bus_read(2'd3, r);
      check(r == 8'h08, "R9 flag cleared by one write", r, 8'h08);
      send_frame(8'h5A, 8, 1, 1'b0, 1'b1);
      bus_read(2'd3, r);
      check(r[0] == 1'b0, "R6 good parity sets no flag", r[0], 0);
      bus_read(2'd0, r);
   endtask

   task automatic t_ferr();
      logic [7:0] r;
      bus_write(2'd1, 8'h03);
      send_frame(8'hC3, 8, 0, 1'b0, 1'b0);
      wait_clk(200);
      bus_read(2'd3, r);
      check(r[2:0] == 3'b010, "R7 framing flag only", r[2:0], 3'b010);
      bus_read(2'd0, r);
      check(r == 8'hC3, "R7 char stored despite framing error", r, 8'hC3);
      bus_read(2'd3, r);
      check(r[3] == 1'b1, "R7 no spurious char after low stop", r[3], 1);
      bus_write(2'd3, 8'h07);
   endtask

   task automatic t_glitch();
      logic [7:0] r;
      drv_rxd = 1'b0;
      wait_clk(12);
      drv_rxd = 1'b1;
      wait_clk(400);
      bus_read(2'd3, r);
      check(r == 8'h08, "R5 short low pulse gives no char", r, 8'h08);
   endtask

   task automatic t_overrun();
      logic [7:0] r;
      bus_write(2'd1, 8'h03);
      for (int i = 0; i < 5; i++) send_frame(8'h11 + 8'(i), 8, 0, 1'b0, 1'b1);
      bus_read(2'd3, r);
      check(r[2] == 1'b1, "R8 overrun flag", r[2], 1);
      for (int i = 0; i < 4; i++) begin
         bus_read(2'd0, r);
         check(r == 8'h11 + 8'(i), "R8 fifo contents kept on overrun", r, 8'h11 + i);
      end
      bus_read(2'd3, r);
      check(r[3] == 1'b1, "R8 dropped char not stored", r[3], 1);
      bus_write(2'd3, 8'h04);
      bus_read(2'd3, r);
      check(r == 8'h08, "R9 overrun flag cleared", r, 8'h08);
   endtask

   task automatic t_rts();
      logic [7:0] r;
      bus_write(2'd1, 8'h13);
      check(rts_n == 1'b0, "R11 rts low with empty fifo", rts_n, 0);
      send_frame(8'h21, 8, 0, 1'b0, 1'b1);
      send_frame(8'h22, 8, 0, 1'b0, 1'b1);
      check(rts_n == 1'b0, "R11 rts low below level", rts_n, 0);
      send_frame(8'h23, 8, 0, 1'b0, 1'b1);
      check(rts_n == 1'b1, "R11 rts high at level", rts_n, 1);
      bus_read(2'd0, r);
      @(negedge clk);
      check(rts_n == 1'b0, "R11 rts low after pop below level", rts_n, 0);
      bus_write(2'd1, 8'h03);
      bus_read(2'd0, r);
      bus_write(2'd1, 8'h13);
      bus_read(2'd0, r);
      bus_write(2'd1, 8'h03);
      check(rts_n == 1'b0, "R11 rts low with flow disabled", rts_n, 0);
   endtask

   task automatic t_cts();
      logic [7:0] r, v;
      logic pb, so, sp;
      int base;
      bus_write(2'd2, 8'h00);
      bus_write(2'd1, 8'h13);
      cts_n = 1'b1;
      wait_clk(4);
      base = fall_cnt;
      bus_write(2'd0, 8'h31);
      bus_write(2'd0, 8'h42);
      bus_write(2'd0, 8'h53);
      bus_write(2'd0, 8'h64);
      bus_read(2'd3, r);
      check(r[4] == 1'b1, "R12 tx fifo full flag", r[4], 1);
      bus_write(2'd0, 8'hEE);
      wait_clk(1200);
      check(fall_cnt == base, "R10 no start while cts high", fall_cnt - base, 0);
      cts_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         decode_tx(8, 1'b0, v, pb, so, sp);
         check(v == 8'h31 + 8'h11 * 8'(i) && so && sp, "R12 tx fifo order", v,
               8'h31 + 8'h11 * i);
      end
      base = fall_cnt;
      wait_clk(1500);
      check(fall_cnt == base, "R12 write to full tx fifo dropped", fall_cnt - base, 0);
      bus_write(2'd1, 8'h03);
      cts_n = 1'b1;
      bus_write(2'd0, 8'h96);
      decode_tx(8, 1'b0, v, pb, so, sp);
      check(v == 8'h96 && so, "R10 cts ignored when flow disabled", v, 8'h96);
      cts_n = 1'b0;
      wait_clk(200);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_loop(8'h03, 8'hA5, 8, 1'b0, 8'hA5, 1'b0, "8N1");
      t_loop(8'h04, 8'hFC, 5, 1'b1, 8'h1C, 1'b1, "5E1");
      t_loop(8'h0A, 8'hB3, 7, 1'b1, 8'h33, 1'b1, "7O1");
      t_stop(5'd0);
      t_stop(5'd8);
      t_stop(5'd16);
      t_stop(5'd31);
      t_perr();
      t_ferr();
      t_glitch();
      t_overrun();
      t_rts();
      t_cts();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule